// File: doc/BRIEF.md
# Fetch/Execute Sequencer with Branch Delay Slot

This block controls the instruction flow of a short in-order pipeline. It drives the fetch address and the fetch request. It keeps valid, class and address tags for an execute stage and for a memory stage, and it decides when a fetch has to wait. Ordinary arithmetic and no-op instructions take two phases: fetch, then execute. Loads and stores take a third phase in which the data transfer uses the memory port. The block has no ALU, register file or decoder. An external decoder supplies the class and the branch target of the word being fetched.

A taken jump does not redirect fetch at once. The word directly after the jump is always fetched and executed. Only the fetch after that one goes to the target. Instructions are fixed 4-byte words. The memory port can be configured per cycle as a single shared port or as two independent ports. On a single shared port, a data transfer in the memory stage takes the cycle from instruction fetch. A memory-ready input freezes the whole block while it is low.

Top module: `dslot_seq`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to 0, clears both stage valid flags and the error flag, and leaves the fetch request high.
- R2: Every completed fetch places that word in the execute stage on the next cycle, with its address and class. A cycle with no completed fetch leaves the execute stage empty on the next cycle.
- R3: A word of class load/store (code 1) in the execute stage occupies the memory stage on the next cycle, with the same address. Classes 0 (arithmetic), 2 (taken jump) and 3 (no-op) never enter the memory stage.
- R4: With the single-port setting (dual-port input low), while the memory stage is valid the fetch request is low and the stall output is high. The fetch address is held, and the execute stage is empty on the next cycle.
- R5: With the dual-port setting, the fetch request stays high and no stall occurs, even while the memory stage is valid.
- R6: A completed fetch of a word that is not a delay slot advances the fetch address by 4. This includes a jump word.
- R7: After a jump (class 2) is fetched, the next fetched word is the delay slot at the jump address plus 4. The slot always enters the execute stage. The fetch after the slot uses the target that was captured with the jump.
- R8: A jump fetched in a delay slot raises the error output for exactly one cycle. Its own target is ignored, and fetch continues at the first jump's target.
- R9: While memory-ready is low, the fetch address, both stages and the pending redirect hold their values, and the error output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dual_port | input | 1 | 1: fetch and data transfer may share a cycle; 0: one access per cycle |
| mem_rdy | input | 1 | Memory ready; low freezes every stage |
| in_cls | input | 2 | Class of the word being fetched: 0 arithmetic, 1 load/store, 2 taken jump, 3 no-op |
| in_target | input | AW | Jump target of the word being fetched |
| fetch_req | output | 1 | Instruction fetch requested this cycle |
| fetch_pc | output | AW | Fetch address |
| fetch_stall | output | 1 | Fetch held back by a data transfer on the shared port |
| ex_valid | output | 1 | Execute stage holds a word |
| ex_cls | output | 2 | Class of the execute-stage word |
| ex_pc | output | AW | Address of the execute-stage word |
| mem_valid | output | 1 | Memory stage holds a load/store (data port access) |
| mem_pc | output | AW | Address of the memory-stage word |
| seq_err | output | 1 | One-cycle pulse: jump found in a delay slot |

## Verification
The bench builds the block with the default 32-bit address and 4-byte word step. With these values the fetch addresses, jump targets and address increments can be predicted exactly. The run switches the port setting between single and dual. It includes back-to-back loads, a load in a delay slot, a jump placed in a slot, and a memory-ready input that drops for single cycles. Together these reach the stall path, the redirect after the slot, the illegal-sequence pulse and the freeze. A second reset in the middle of the run checks the state the block restarts from.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
  typedef enum logic [1:0] {
    CLS_ALU  = 2'd0,
    CLS_LDST = 2'd1,
    CLS_JMP  = 2'd2,
    CLS_NOP  = 2'd3
  } icls_t;
endpackage

// File: rtl/seq_arb.sv
`timescale 1ns/1ps
// Memory port arbitration: decides whether the fetch may use the port this cycle.
module seq_arb (
  input  logic dual_port,
  input  logic mem_busy,
  output logic grant,
  output logic stall
);
  always_comb begin
    grant = dual_port || !mem_busy;
    stall = !grant;
  end
endmodule

// File: rtl/seq_fetch.sv
`timescale 1ns/1ps
// Fetch address generation with a one-word delay slot before any redirect.
module seq_fetch #(
  parameter int AW          = 32,
  parameter int INSTR_BYTES = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rdy,
  input  logic          grant,
  input  logic [1:0]    in_cls,
  input  logic [AW-1:0] in_target,
  output logic [AW-1:0] pc,
  output logic          err
);
  import seq_pkg::*;
  localparam logic [AW-1:0] STEP = AW'(INSTR_BYTES);

  logic          pend;
  logic [AW-1:0] tgt;
  logic          take;
  logic          is_jmp;

  always_comb begin
    take   = rdy && grant;
    is_jmp = (icls_t'(in_cls) == CLS_JMP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= RESET_PC;
      pend <= 1'b0;
      tgt  <= '0;
      err  <= 1'b0;
    end else begin
      err <= take && pend && is_jmp;
      if (take) begin
        if (pend) begin
          pc   <= tgt;
          pend <= 1'b0;
        end else begin
          pc <= pc + STEP;
          if (is_jmp) begin
            pend <= 1'b1;
            tgt  <= in_target;
          end
        end
      end
    end
  end

  // R6: plain fetch steps by one word
  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    (rdy && grant && !pend) |=> (pc == $past(pc) + STEP));
  // R7: the fetch after the slot goes to the captured target
  a_r7_redirect: assert property (@(posedge clk) disable iff (rst)
    (rdy && grant && pend) |=> (pc == $past(tgt) && !pend));
  // R8: error is a single-cycle pulse
  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
  // R9: frozen while memory is not ready
  a_r9_hold_pc: assert property (@(posedge clk) disable iff (rst)
    !rdy |=> ($stable(pc) && $stable(pend) && !err));
endmodule

// File: rtl/seq_pipe.sv
`timescale 1ns/1ps
// Execute and memory stage tags.
module seq_pipe #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rdy,
  input  logic          grant,
  input  logic [1:0]    in_cls,
  input  logic [AW-1:0] pc,
  output logic          ex_valid,
  output logic [1:0]    ex_cls,
  output logic [AW-1:0] ex_pc,
  output logic          mem_valid,
  output logic [AW-1:0] mem_pc
);
  import seq_pkg::*;

  icls_t ex_cls_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid  <= 1'b0;
      ex_cls_q  <= CLS_NOP;
      ex_pc     <= '0;
      mem_valid <= 1'b0;
      mem_pc    <= '0;
    end else if (rdy) begin
      mem_valid <= ex_valid && (ex_cls_q == CLS_LDST);
      mem_pc    <= ex_pc;
      ex_valid  <= grant;
      if (grant) begin
        ex_cls_q <= icls_t'(in_cls);
        ex_pc    <= pc;
      end
    end
  end

  assign ex_cls = ex_cls_q;

  // R2: a granted fetch lands in execute with the fetch address
  a_r2_enter: assert property (@(posedge clk) disable iff (rst)
    (rdy && grant) |=> (ex_valid && ex_pc == $past(pc)));
  // R3: load/store moves on to the memory stage
  a_r3_ldst: assert property (@(posedge clk) disable iff (rst)
    (rdy && ex_valid && ex_cls_q == CLS_LDST) |=> (mem_valid && mem_pc == $past(ex_pc)));
  // R9: stages frozen while memory is not ready
  a_r9_hold_stages: assert property (@(posedge clk) disable iff (rst)
    !rdy |=> $stable({ex_valid, ex_pc, mem_valid, mem_pc}));
endmodule

// File: rtl/dslot_seq.sv
`timescale 1ns/1ps
module dslot_seq #(
  parameter int AW          = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dual_port,
  input  logic          mem_rdy,
  input  logic [1:0]    in_cls,
  input  logic [AW-1:0] in_target,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_pc,
  output logic          fetch_stall,
  output logic          ex_valid,
  output logic [1:0]    ex_cls,
  output logic [AW-1:0] ex_pc,
  output logic          mem_valid,
  output logic [AW-1:0] mem_pc,
  output logic          seq_err
);
  logic grant;

  seq_arb u_arb (
    .dual_port (dual_port),
    .mem_busy  (mem_valid),
    .grant     (grant),
    .stall     (fetch_stall)
  );

  seq_fetch #(.AW(AW), .INSTR_BYTES(INSTR_BYTES)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .rdy       (mem_rdy),
    .grant     (grant),
    .in_cls    (in_cls),
    .in_target (in_target),
    .pc        (fetch_pc),
    .err       (seq_err)
  );

  seq_pipe #(.AW(AW)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .rdy       (mem_rdy),
    .grant     (grant),
    .in_cls    (in_cls),
    .pc        (fetch_pc),
    .ex_valid  (ex_valid),
    .ex_cls    (ex_cls),
    .ex_pc     (ex_pc),
    .mem_valid (mem_valid),
    .mem_pc    (mem_pc)
  );

  assign fetch_req = grant;

  // R1: state right after reset
  a_r1_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fetch_pc == '0 && !ex_valid && !mem_valid && !seq_err && fetch_req));
  // R4: shared port, data transfer leaves a bubble in execute
  a_r4_bubble: assert property (@(posedge clk) disable iff (rst)
    (!dual_port && mem_rdy && mem_valid) |=> !ex_valid);
  // R5: dual port never starves fetch
  a_r5_nostall: assert property (@(posedge clk) disable iff (rst)
    (dual_port && mem_rdy) |=> ex_valid);
endmodule

// File: tb/sim_dslot_seq.sv
`timescale 1ns/1ps
module sim_dslot_seq;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dual_port = 1'b0;
  logic          mem_rdy = 1'b1;
  logic [1:0]    in_cls = 2'd0;
  logic [AW-1:0] in_target = '0;
  logic          fetch_req, fetch_stall, ex_valid, mem_valid, seq_err;
  logic [AW-1:0] fetch_pc, ex_pc, mem_pc;
  logic [1:0]    ex_cls;

  always #2.5 clk = ~clk;

  dslot_seq #(.AW(AW), .INSTR_BYTES(4)) u0 (
    .clk(clk), .rst(rst), .dual_port(dual_port), .mem_rdy(mem_rdy),
    .in_cls(in_cls), .in_target(in_target),
    .fetch_req(fetch_req), .fetch_pc(fetch_pc), .fetch_stall(fetch_stall),
    .ex_valid(ex_valid), .ex_cls(ex_cls), .ex_pc(ex_pc),
    .mem_valid(mem_valid), .mem_pc(mem_pc), .seq_err(seq_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  bit          started = 0;
  bit          just_reset = 0;
  bit          redir_last = 0;
  bit          rdy_last = 1;
  bit          stall_last = 0;
  logic [31:0] q_pc, q_tgt, q_epc, q_mpc;
  bit          q_pend, q_ev, q_mv, q_err;
  logic [1:0]  q_ecls;
  int          n_fetch = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] pick_cls(input int n);
    if (n == 30 || n == 31) return 2'd2;   // jump inside a delay slot
    if (n % 13 == 4)        return 2'd2;
    if (n % 6 == 1)         return 2'd1;
    if (n % 7 == 2)         return 2'd1;
    if (n % 4 == 3)         return 2'd3;
    return 2'd0;
  endfunction

  task automatic compare();
    bit ok;
    string t;
    ok = dual_port || !q_mv;
    if (just_reset) begin
      chk("R1", "fetch_pc", fetch_pc, 32'h0);
      chk("R1", "ex_valid", ex_valid, 0);
      chk("R1", "mem_valid", mem_valid, 0);
      chk("R1", "seq_err", seq_err, 0);
      chk("R1", "fetch_req", fetch_req, 1);
      return;
    end
    t = redir_last ? "R7" : (!rdy_last ? "R9" : "R6");
    chk(t, "fetch_pc", fetch_pc, q_pc);
    t = dual_port ? "R5" : "R4";
    chk(t, "fetch_req", fetch_req, ok);
    chk(t, "fetch_stall", fetch_stall, !ok);
    t = !rdy_last ? "R9" : (stall_last ? "R4" : "R2");
    chk(t, "ex_valid", ex_valid, q_ev);
    if (q_ev) begin
      chk(t, "ex_pc", ex_pc, q_epc);
      chk(t, "ex_cls", ex_cls, q_ecls);
    end
    t = !rdy_last ? "R9" : "R3";
    chk(t, "mem_valid", mem_valid, q_mv);
    if (q_mv) chk(t, "mem_pc", mem_pc, q_mpc);
    chk(!rdy_last ? "R9" : "R8", "seq_err", seq_err, q_err);
  endtask

  task automatic model_next();
    bit ok;
    ok = dual_port || !q_mv;
    just_reset = 0;
    redir_last = 0;
    if (rst) begin
      q_pc = 0; q_pend = 0; q_tgt = 0; q_ev = 0; q_mv = 0; q_err = 0;
      q_ecls = 2'd3; q_epc = 0; q_mpc = 0;
      started = 1; just_reset = 1; rdy_last = 1; stall_last = 0;
      return;
    end
    rdy_last = mem_rdy;
    stall_last = !ok;
    q_err = 0;
    if (!mem_rdy) return;
    q_err = ok && q_pend && (in_cls == 2'd2);
    q_mv  = q_ev && (q_ecls == 2'd1);
    q_mpc = q_epc;
    q_ev  = ok;
    if (ok) begin
      q_ecls = in_cls;
      q_epc  = q_pc;
      if (q_pend) begin
        q_pc = q_tgt; q_pend = 0; redir_last = 1;
      end else begin
        if (in_cls == 2'd2) begin
          q_pend = 1; q_tgt = in_target;
        end
        q_pc = q_pc + 4;
      end
      n_fetch++;
    end
  endtask

  initial begin
    for (int c = 0; c < 620; c++) begin
      @(negedge clk);
      if (started) compare();
      rst = (c < 3) || (c >= 450 && c < 453);
      if (c < 150)      begin dual_port = 0; mem_rdy = 1; end
      else if (c < 300) begin dual_port = 1; mem_rdy = 1; end
      else if (c < 453) begin dual_port = c[3]; mem_rdy = (c % 5 != 2); end
      else              begin dual_port = 0; mem_rdy = (c % 7 != 0); end
      in_cls    = pick_cls(n_fetch);
      in_target = 32'((n_fetch * 20 + 64) & 32'hFFC);
      model_next();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule